// File: doc/BRIEF.md
# Accumulator Store Rounding Formatter

This block turns an extended 48-bit multiply-accumulate register into a 32-bit register value when a store strobe arrives. The accumulator holds 8 extension bits on top and a 40-bit fraction below them. The formatter reads only the fraction. Two mode inputs pick the result format: a full 32-bit fraction, or a 16-bit fraction placed in the upper half of the word. A second input picks truncation or round-to-nearest-even.

The part of the fraction that is thrown away is the guard field. It is 8 bits wide for the 32-bit format and 24 bits wide for the 16-bit format. In round mode, this field and the lowest kept bit together decide whether the kept value is incremented. If an increment would carry the largest positive value over into the negative range, the result stays at the largest positive value instead. The result is registered and appears one cycle after the strobe, together with a one-cycle valid pulse.

Top module: `acc_store_fmt`

## Requirements
- R1: With round_i=0 and narrow_i=0, the result one cycle after a store is acc_i[39:8]; accumulator bits [7:0] are discarded with no rounding.
- R2: With round_i=1 and narrow_i=0, the kept value acc_i[39:8] is incremented by one when acc_i[7:0] is greater than 0x80, and left unchanged when it is less than 0x80.
- R3: With round_i=1 and narrow_i=0, when acc_i[7:0] equals exactly 0x80, the kept value is incremented only if its bit 0 is 1, so the result is even.
- R4: With narrow_i=1, res_o[31:16] is acc_i[39:24], rounded in round mode using acc_i[23:0] (incremented when that field is above 0x800000), and res_o[15:0] is zero.
- R5: With round_i=1 and narrow_i=1, when acc_i[23:0] equals exactly 0x800000, the 16-bit kept value is incremented only if its bit 0 is 1.
- R6: A rounding increment applied to the largest positive value of the selected format (0x7FFFFFFF, or 0x7FFF in the upper half) leaves that value unchanged. An increment from all ones (minus one) gives zero.
- R7: res_o and valid_o are registered. valid_o is 1 in exactly the cycle after each cycle with store_i=1, and res_o changes only in those cycles. Back-to-back strobes give back-to-back results.
- R8: Accumulator extension bits acc_i[47:40] have no effect on the result.
- R9: While rst_ni is low, res_o is 0 and valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| store_i | input | 1 | Store strobe, one result per high cycle |
| acc_i | input | 48 | Extended accumulator: [47:40] extension, [39:0] fraction |
| round_i | input | 1 | 1 = round to nearest even, 0 = truncate |
| narrow_i | input | 1 | 1 = 16-bit fraction in the upper half, 0 = 32-bit fraction |
| res_o | output | 32 | Formatted register value |
| valid_o | output | 1 | One-cycle pulse marking a new res_o |

## Verification
A wrong increment decision shows up as an off-by-one in the lowest kept bit of the result that goes with that strobe. It appears exactly one cycle after the strobe, so ties and values just above and below the half point are driven directly in both formats. A faulty saturation path shows up as a sign flip on the first increment from the largest positive value. A faulty output register shows up as a valid pulse that is missing or extra, or as res_o drifting in cycles with no strobe. The scoreboard catches each of these on the cycle where it occurs.

// File: rtl/acc_store_fmt_pkg.sv
package acc_store_fmt_pkg;
  parameter int ACC_W    = 48;
  parameter int EXT_W    = 8;
  parameter int RES_W    = 32;
  parameter int NARROW_W = 16;
  localparam int FRAC_W  = ACC_W - EXT_W;

  typedef enum logic {
    FMT_WIDE   = 1'b0,
    FMT_NARROW = 1'b1
  } fmt_e;
endpackage

// File: rtl/round_decide.sv
module round_decide #(
  parameter int DROP_W = 8
) (
  input  logic              round_en_i,
  input  logic [DROP_W-1:0] drop_i,
  input  logic              keep_lsb_i,
  output logic              inc_o
);
  localparam logic [DROP_W-1:0] HALF = {1'b1, {(DROP_W-1){1'b0}}};

  logic above, tie;

  always_comb begin
    above = drop_i > HALF;
    tie   = drop_i == HALF;
    inc_o = round_en_i & (above | (tie & keep_lsb_i));
  end

  always_comb begin
    p_trunc_no_inc_r1: assert (round_en_i || !inc_o)
      else $error("increment in truncate mode");
    p_inc_needs_half_r2: assert (!inc_o || drop_i >= HALF)
      else $error("increment below half point");
  end
endmodule

// File: rtl/sat_incr.sv
module sat_incr #(
  parameter int W = 32
) (
  input  logic [W-1:0] val_i,
  input  logic         inc_i,
  output logic [W-1:0] out_o
);
  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};

  logic at_max;

  always_comb begin
    at_max = val_i == MAX_POS;
    if (inc_i && !at_max) out_o = val_i + 1'b1;
    else                  out_o = val_i;
  end

  // a signed increment that never decreases is one that never wraps
  always_comb begin
    p_no_wrap_r6: assert ($signed(out_o) >= $signed(val_i))
      else $error("rounding carry wrapped");
  end
endmodule

// File: rtl/round_lane.sv
module round_lane #(
  parameter int FRAC_W = 40,
  parameter int KEEP_W = 32
) (
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              round_en_i,
  output logic [KEEP_W-1:0] res_o
);
  localparam int DROP_W = FRAC_W - KEEP_W;

  logic [KEEP_W-1:0] kept;
  logic [DROP_W-1:0] drop;
  logic              inc;

  assign kept = frac_i[FRAC_W-1 -: KEEP_W];
  assign drop = frac_i[DROP_W-1:0];

  round_decide #(.DROP_W(DROP_W)) u_decide (
    .round_en_i (round_en_i),
    .drop_i     (drop),
    .keep_lsb_i (kept[0]),
    .inc_o      (inc)
  );

  sat_incr #(.W(KEEP_W)) u_incr (
    .val_i (kept),
    .inc_i (inc),
    .out_o (res_o)
  );
endmodule

// File: rtl/acc_store_fmt.sv
module acc_store_fmt
  import acc_store_fmt_pkg::*;
#(
  parameter int P_ACC_W    = ACC_W,
  parameter int P_EXT_W    = EXT_W,
  parameter int P_RES_W    = RES_W,
  parameter int P_NARROW_W = NARROW_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               store_i,
  input  logic [P_ACC_W-1:0] acc_i,
  input  logic               round_i,
  input  logic               narrow_i,
  output logic [P_RES_W-1:0] res_o,
  output logic               valid_o
);
  localparam int LFRAC_W = P_ACC_W - P_EXT_W;
  localparam int N_FMT   = 2;

  logic [LFRAC_W-1:0] frac;
  logic [P_EXT_W-1:0] unused_ext;
  logic [P_RES_W-1:0] placed [N_FMT];
  logic [P_RES_W-1:0] res_d;
  fmt_e               fmt;

  assign frac       = acc_i[LFRAC_W-1:0];
  assign unused_ext = acc_i[P_ACC_W-1:LFRAC_W];
  assign fmt        = fmt_e'(narrow_i);

  for (genvar g = 0; g < N_FMT; g++) begin : g_lane
    localparam int KW = (g == int'(FMT_NARROW)) ? P_NARROW_W : P_RES_W;
    logic [KW-1:0] lane_res;

    round_lane #(.FRAC_W(LFRAC_W), .KEEP_W(KW)) u_lane (
      .frac_i     (frac),
      .round_en_i (round_i),
      .res_o      (lane_res)
    );

    // left-align the lane result in the register word
    assign placed[g] = P_RES_W'(lane_res) << (P_RES_W - KW);
  end

  assign res_d = placed[fmt];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= store_i;
      if (store_i) res_o <= res_d;
    end
  end

  p_valid_after_store_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_i |=> valid_o);
  p_no_spurious_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !store_i |=> !valid_o);
  p_hold_between_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !store_i |=> $stable(res_o));
  p_narrow_low_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_i && narrow_i) |=> (res_o[P_RES_W-P_NARROW_W-1:0] == '0));
endmodule

// File: tb/acc_store_fmt_bench.sv
`timescale 1ns/1ps
module acc_store_fmt_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        store_i = 1'b0;
  logic [47:0] acc_i = '0;
  logic        round_i = 1'b0;
  logic        narrow_i = 1'b0;
  logic [31:0] res_o;
  logic        valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] last_res = '0;
  bit          seen = 0;

  always #4 clk_i = ~clk_i;

  acc_store_fmt u_acc_store_fmt (
    .clk_i, .rst_ni, .store_i, .acc_i, .round_i, .narrow_i, .res_o, .valid_o
  );

  function automatic logic [31:0] model(logic [47:0] a, logic rnd, logic nar);
    longint k, d, half, maxp, kw;
    bit up;
    if (nar) begin
      k = longint'(a[39:24]); d = longint'(a[23:0]); half = 64'h80_0000; kw = 16;
    end else begin
      k = longint'(a[39:8]);  d = longint'(a[7:0]);  half = 64'h80; kw = 32;
    end
    maxp = (64'd1 << (kw - 1)) - 1;
    up = rnd && ((d > half) || (d == half && k[0]));
    if (up && k != maxp) k = (k + 1) & ((64'd1 << kw) - 1);
    return nar ? (32'(k) << 16) : 32'(k);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(logic [47:0] a, logic rnd, logic nar, logic [31:0] exp, string tag);
    acc_i = a; round_i = rnd; narrow_i = nar; store_i = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk_i);
  endtask

  task automatic idle(int n);
    store_i = 1'b0;
    acc_i = 48'hDEAD_BEEF_CAFE;
    repeat (n) @(negedge clk_i);
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (valid_o) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R7: unexpected valid, got %h expected no result", res_o);
        end else begin
          check(tag_q.pop_front(), res_o, exp_q.pop_front());
        end
        last_res = res_o; seen = 1;
      end else if (seen) begin
        check("R7 hold", res_o, last_res);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R9 res", res_o, 32'h0);
    check("R9 valid", {31'b0, valid_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    send(48'hAB_12345678_FF, 0, 0, 32'h12345678, "R1 trunc"); idle(2);
    send(48'h00_12345678_81, 1, 0, 32'h12345679, "R2 above"); idle(1);
    send(48'h00_12345678_7F, 1, 0, 32'h12345678, "R2 below"); idle(1);
    send(48'h00_12345678_80, 1, 0, 32'h12345678, "R3 tie even"); idle(1);
    send(48'h00_12345679_80, 1, 0, 32'h1234567A, "R3 tie odd"); idle(1);
    send(48'h00_1234_FFFFFF, 0, 1, 32'h12340000, "R4 trunc"); idle(1);
    send(48'h00_1234_800001, 1, 1, 32'h12350000, "R4 above"); idle(1);
    send(48'h00_1234_7FFFFF, 1, 1, 32'h12340000, "R4 below"); idle(1);
    send(48'h00_1234_800000, 1, 1, 32'h12340000, "R5 tie even"); idle(1);
    send(48'h00_1235_800000, 1, 1, 32'h12360000, "R5 tie odd"); idle(1);
    send(48'h00_7FFFFFFF_FF, 1, 0, 32'h7FFFFFFF, "R6 wide max"); idle(1);
    send(48'h00_7FFF_FFFFFF, 1, 1, 32'h7FFF0000, "R6 narrow max"); idle(1);
    send(48'h00_FFFFFFFF_80, 1, 0, 32'h00000000, "R6 minus one"); idle(1);
    send(48'hFF_12345678_81, 1, 0, 32'h12345679, "R8 ext ones");
    send(48'h5A_12345678_81, 1, 0, 32'h12345679, "R8 ext mix");
    send(48'h3C_7FFF_800000, 1, 1, 32'h7FFF0000, "R8 narrow");
    idle(3);
    // back-to-back strobes
    for (int i = 0; i < 6; i++) begin
      logic [47:0] a = {$urandom, $urandom};
      send(a, i[0], i[1], model(a, i[0], i[1]), "R7 burst");
    end
    idle(2);
    for (int i = 0; i < 300; i++) begin
      logic [47:0] a = {$urandom, $urandom};
      logic r = $urandom % 2;
      logic n = $urandom % 2;
      if (i % 4 == 0) a[7:0] = 8'h80;
      if (i % 4 == 1) a[23:0] = 24'h80_0000;
      send(a, r, n, model(a, r, n), n ? (r ? "R5 rand" : "R4 rand") : (r ? "R2 rand" : "R1 rand"));
      if ($urandom % 3 == 0) idle(1 + $urandom % 3);
    end
    idle(3);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R7: got %0d pending expected 0", exp_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule